// File: doc/BRIEF.md
# Periodic Measurement Sequencer

This block schedules the conversions of an on-chip temperature sensor. It divides the fabric clock into a slower conversion-clock enable, and after an enable and a start command it waits a programmable power-up delay. It then runs conversions in one of three modes: a single conversion, back-to-back conversions, or conversions launched at a fixed period. The analog converter is modelled as a counter whose length follows a two-bit resolution code. Each finished conversion latches the value presented on the sample input, gives a one-cycle done pulse and raises a data-ready flag.

A stop command ends the run once the conversion in flight has finished. Dropping enable abandons the run at once. Mode and resolution are captured when a run starts. The divider value, power-up delay and period are read live while the run is in progress.

Top module: `meas_sequencer`

## Requirements
- R1: After reset, busy, done and data_ready are 0 and sample_out is 0.
- R2: The conversion clock ticks once per clock when div_en is 0, and once every div_val+1 clocks when div_en is 1. Ticks are counted from the start edge. In single mode, done rises (pud+L)*(d+1) clocks after the start edge, where d is div_val when div_en is 1 and 0 otherwise.
- R3: After a start, the sequencer waits pud conversion-clock ticks before the first conversion begins. With pud equal to 0, the conversion begins at the start edge.
- R4: The resolution code selects the conversion length L in ticks: code 0 gives CONV_LEN0, 1 gives CONV_LEN1, 2 gives CONV_LEN2 and 3 gives CONV_LEN3.
- R5: Mode code 0 (and the reserved code 3) runs a single conversion and then returns to idle, with busy low.
- R6: Mode code 1 starts the next conversion as soon as the previous one ends, so done repeats every L ticks.
- R7: Mode code 2 starts conversions max(period, L) ticks apart. The spacing is measured from the start of one conversion to the start of the next.
- R8: Each finished conversion gives a done pulse one clock wide, latches sample_in into sample_out on the same edge, and sets data_ready.
- R9: data_ready stays set until ready_clr is asserted. If a conversion finishes in the same cycle as ready_clr, the flag is set.
- R10: A stop command ends the run at the end of the current conversion, or at once when it arrives between conversions. No further conversion starts after it. A stop command while idle has no effect.
- R11: When enable is low, the sequencer is idle after the next clock edge, and no done pulse comes from the aborted work.
- R12: A start command while busy is ignored. Mode and resolution are sampled at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sequencer enable; low aborts and holds idle |
| start | input | 1 | One-cycle start command |
| stop | input | 1 | One-cycle stop command |
| mode | input | 2 | 0 single, 1 continuous, 2 periodic, 3 as single |
| res | input | 2 | Resolution code selecting conversion length |
| div_en | input | 1 | Divider enable |
| div_val | input | DIV_W | Divide value; tick every div_val+1 clocks |
| pud | input | PUD_W | Power-up delay in ticks |
| period | input | PER_W | Periodic start spacing in ticks |
| sample_in | input | SAMPLE_W | Converter result captured at conversion end |
| ready_clr | input | 1 | Clears data_ready |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle conversion-complete pulse |
| data_ready | output | 1 | Sticky new-data flag |
| sample_out | output | SAMPLE_W | Last latched sample |

## Verification
The hardest states to reach are stops and aborts that land mid-run. The cases are a stop arriving in the middle of a second back-to-back conversion, a stop arriving in the idle gap between periodic conversions, and enable falling during a long conversion. The bench reaches them by first waiting for an observed done pulse and then timing the command a fixed number of clocks later. It then counts done pulses until busy falls, and watches a quiet window afterwards. The bench shrinks the conversion lengths to small values so that every resolution code, power-up delay and divider setting can be swept, each against a closed-form cycle count.

// File: rtl/ms_pkg.sv
package ms_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PWRUP = 2'd1,
      ST_CONV  = 2'd2,
      ST_WAIT  = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      MD_SINGLE   = 2'd0,
      MD_CONT     = 2'd1,
      MD_PERIODIC = 2'd2,
      MD_RSVD     = 2'd3
   } meas_mode_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
   parameter int DIV_W   = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div_en,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_W-1:0] dcnt;
         logic [DIV_W-1:0] limit;
         assign limit = div_en ? div_val : '0;
         assign tick  = run && (dcnt == limit);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dcnt <= '0;
            else if (!run || dcnt >= limit)
               dcnt <= '0;
            else
               dcnt <= dcnt + 1'b1;
         end

         // R2
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && div_en && div_val != '0 && $stable(div_val)) |=> !tick);
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = div_en ^ (^div_val);
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/ms_fsm.sv
module ms_fsm
   import ms_pkg::*;
#(
   parameter int PUD_W     = 8,
   parameter int PER_W     = 24,
   parameter int CONV_LEN0 = 2373,
   parameter int CONV_LEN1 = 4421,
   parameter int CONV_LEN2 = 8517,
   parameter int CONV_LEN3 = 16709
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start,
   input  logic             stop,
   input  logic [1:0]       mode,
   input  logic [1:0]       res,
   input  logic [PUD_W-1:0] pud,
   input  logic [PER_W-1:0] period,
   input  logic             tick,
   output logic             busy,
   output logic             conv_fire
);
   localparam int LEN_MAX = max2(max2(CONV_LEN0, CONV_LEN1), max2(CONV_LEN2, CONV_LEN3));
   localparam int CW      = $clog2(LEN_MAX + 1);
   localparam int PHW     = max2(CW, PUD_W);
   localparam int PCW     = max2(PER_W, PHW) + 1;

   initial begin
      assert (CONV_LEN0 >= 2 && CONV_LEN1 >= 2 && CONV_LEN2 >= 2 && CONV_LEN3 >= 2)
         else $error("conversion lengths must be at least 2 ticks");
      assert (PUD_W >= 1 && PER_W >= 1) else $error("field widths must be positive");
   end

   seq_state_t       st;
   meas_mode_t       mode_q;
   logic [1:0]       res_q;
   logic [PHW-1:0]   ph;
   logic [PCW-1:0]   pc;
   logic             stop_pend;
   logic [PHW-1:0]   len_sel;
   logic             halt;
   logic             per_due;
   logic             conv_end;

   always_comb begin
      unique case (res_q)
         2'd0:    len_sel = PHW'(CONV_LEN0);
         2'd1:    len_sel = PHW'(CONV_LEN1);
         2'd2:    len_sel = PHW'(CONV_LEN2);
         default: len_sel = PHW'(CONV_LEN3);
      endcase
   end

   assign busy      = (st != ST_IDLE);
   assign halt      = stop_pend || stop;
   assign per_due   = (pc + 1'b1) >= PCW'(period);
   assign conv_end  = (st == ST_CONV) && tick && (ph == len_sel - 1'b1);
   assign conv_fire = enable && conv_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         mode_q    <= MD_SINGLE;
         res_q     <= '0;
         ph        <= '0;
         pc        <= '0;
         stop_pend <= 1'b0;
      end else if (!enable) begin
         st        <= ST_IDLE;
         ph        <= '0;
         pc        <= '0;
         stop_pend <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               stop_pend <= 1'b0;
               if (start) begin
                  mode_q <= meas_mode_t'(mode);
                  res_q  <= res;
                  ph     <= '0;
                  pc     <= '0;
                  st     <= (pud == '0) ? ST_CONV : ST_PWRUP;
               end
            end
            ST_PWRUP: begin
               stop_pend <= halt;
               if (tick) begin
                  if (ph == PHW'(pud) - 1'b1) begin
                     ph <= '0;
                     pc <= '0;
                     st <= halt ? ST_IDLE : ST_CONV;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
            end
            ST_CONV: begin
               stop_pend <= halt;
               if (tick) begin
                  pc <= pc + 1'b1;
                  if (ph == len_sel - 1'b1) begin
                     ph <= '0;
                     if (halt || mode_q == MD_SINGLE || mode_q == MD_RSVD) begin
                        st <= ST_IDLE;
                     end else if (mode_q == MD_CONT || per_due) begin
                        pc <= '0;
                        st <= ST_CONV;
                     end else begin
                        st <= ST_WAIT;
                     end
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               stop_pend <= halt;
               if (halt) begin
                  st <= ST_IDLE;
               end else if (tick) begin
                  if (per_due) begin
                     pc <= '0;
                     ph <= '0;
                     st <= ST_CONV;
                  end else begin
                     pc <= pc + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R11
   idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy);

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CONV) |-> (ph < len_sel));

   // R10
   stop_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_fire && halt) |=> !busy);
endmodule

// File: rtl/ms_result.sv
module ms_result #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_fire,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                ready_clr,
   output logic                done,
   output logic                data_ready,
   output logic [SAMPLE_W-1:0] sample_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         data_ready <= 1'b0;
         sample_out <= '0;
      end else begin
         done       <= conv_fire;
         data_ready <= conv_fire || (data_ready && !ready_clr);
         if (conv_fire)
            sample_out <= sample_in;
      end
   end

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> data_ready);

   // R9
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !ready_clr) |=> data_ready);
endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer #(
   parameter int SAMPLE_W  = 16,
   parameter int DIV_W     = 8,
   parameter int PUD_W     = 8,
   parameter int PER_W     = 24,
   parameter bit HAS_DIV   = 1'b1,
   parameter int CONV_LEN0 = 2373,
   parameter int CONV_LEN1 = 4421,
   parameter int CONV_LEN2 = 8517,
   parameter int CONV_LEN3 = 16709
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                start,
   input  logic                stop,
   input  logic [1:0]          mode,
   input  logic [1:0]          res,
   input  logic                div_en,
   input  logic [DIV_W-1:0]    div_val,
   input  logic [PUD_W-1:0]    pud,
   input  logic [PER_W-1:0]    period,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                ready_clr,
   output logic                busy,
   output logic                done,
   output logic                data_ready,
   output logic [SAMPLE_W-1:0] sample_out
);
   logic tick;
   logic conv_fire;

   ms_tick_gen #(.DIV_W(DIV_W), .HAS_DIV(HAS_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .div_en(div_en),
      .div_val(div_val), .tick(tick)
   );

   ms_fsm #(
      .PUD_W(PUD_W), .PER_W(PER_W),
      .CONV_LEN0(CONV_LEN0), .CONV_LEN1(CONV_LEN1),
      .CONV_LEN2(CONV_LEN2), .CONV_LEN3(CONV_LEN3)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .stop(stop),
      .mode(mode), .res(res), .pud(pud), .period(period), .tick(tick),
      .busy(busy), .conv_fire(conv_fire)
   );

   ms_result #(.SAMPLE_W(SAMPLE_W)) u_res (
      .clk(clk), .rst_n(rst_n), .conv_fire(conv_fire), .sample_in(sample_in),
      .ready_clr(ready_clr), .done(done), .data_ready(data_ready),
      .sample_out(sample_out)
   );

   // R12
   start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && enable && start && !done) |=> busy);
endmodule

// File: tb/sim_meas_sequencer.sv
module sim_meas_sequencer;
   localparam int L0 = 3, L1 = 5, L2 = 8, L3 = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, start = 1'b0, stop = 1'b0, ready_clr = 1'b0;
   logic [1:0]  mode = 2'd0, res = 2'd0;
   logic        div_en = 1'b0;
   logic [7:0]  div_val = 8'd0, pud = 8'd0;
   logic [23:0] period = 24'd0;
   logic [15:0] sample_in = 16'd0;
   logic        busy, done, data_ready;
   logic [15:0] sample_out;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   meas_sequencer #(
      .CONV_LEN0(L0), .CONV_LEN1(L1), .CONV_LEN2(L2), .CONV_LEN3(L3)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .stop(stop),
      .mode(mode), .res(res), .div_en(div_en), .div_val(div_val), .pud(pud),
      .period(period), .sample_in(sample_in), .ready_clr(ready_clr),
      .busy(busy), .done(done), .data_ready(data_ready), .sample_out(sample_out)
   );

   function automatic int len_of(input int r);
      case (r)
         0: return L0;
         1: return L1;
         2: return L2;
         default: return L3;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_done(output int n, input int lim);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!done && n < lim);
      if (!done) n = -1;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic setup(input int m, input int r, input int pd, input bit de,
                        input int dv, input int per);
      mode = 2'(m); res = 2'(r); pud = 8'(pd); div_en = de;
      div_val = 8'(dv); period = 24'(per);
   endtask

   task automatic stop_and_idle();
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      for (int i = 0; i < 400 && busy; i++) @(negedge clk);
      ready_clr = 1'b1;
      @(negedge clk);
      ready_clr = 1'b0;
   endtask

   // R2 R3 R4 R5 R8: single-conversion timing and capture
   task automatic run_single(input int m, input int r, input int pd, input bit de,
                             input int dv, input int smp);
      int n, d, exp;
      setup(m, r, pd, de, dv, 0);
      sample_in = 16'(smp);
      d = de ? dv : 0;
      exp = (pd + len_of(r)) * (d + 1) + 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(n, 2000);
      n = (n < 0) ? -1 : n + 1;
      chk(n == exp, "R2/R3/R4 done latency", n, exp);
      chk(sample_out == 16'(smp), "R8 sample latched", int'(sample_out), smp);
      chk(data_ready == 1'b1, "R8 ready set", int'(data_ready), 1);
      chk(busy == 1'b0, "R5 idle after single", int'(busy), 0);
      ready_clr = 1'b1;
      @(negedge clk);
      ready_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_interval(input int m, input int r, input bit de, input int dv,
                               input int per, input int exp, input string req);
      int n;
      setup(m, r, 0, de, dv, per);
      pulse_start();
      wait_done(n, 2000);
      wait_done(n, 2000);
      chk(n == exp, req, n, exp);
      stop_and_idle();
   endtask

   initial begin
      int n, cnt;
      // R1
      #1;
      chk(busy == 0 && done == 0 && data_ready == 0 && sample_out == 0,
          "R1 reset state", int'(busy) + int'(data_ready), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && data_ready == 0 && sample_out == 0,
          "R1 after reset", int'(busy), 0);
      enable = 1'b1;
      @(negedge clk);

      // sweep R2 R3 R4 R5 R8
      for (int r = 0; r < 4; r++)
         for (int p = 0; p < 2; p++)
            for (int dc = 0; dc < 3; dc++)
               run_single(0, r, p * 3, dc != 0, (dc == 2) ? 2 : ((dc == 0) ? 5 : 0),
                          16'h1000 + r * 16 + p * 4 + dc);
      // R5 reserved code behaves as single
      run_single(3, 1, 1, 1'b0, 0, 16'hBEEF);

      // R6 continuous spacing
      run_interval(1, 1, 1'b0, 0, 0, L1, "R6 continuous interval");
      run_interval(1, 0, 1'b1, 2, 0, L0 * 3, "R6 continuous interval divided");
      // R7 periodic spacing
      run_interval(2, 1, 1'b0, 0, 10, 10, "R7 periodic long period");
      run_interval(2, 1, 1'b0, 0, 3, L1, "R7 periodic short period");
      run_interval(2, 0, 1'b1, 1, 10, 20, "R7 periodic divided");

      // R9 ready hold, clear, set-wins
      run_interval(1, 0, 1'b0, 0, 0, L0, "R6 continuous res0");
      setup(0, 0, 0, 1'b0, 0, 0);
      pulse_start();
      wait_done(n, 200);
      repeat (6) @(negedge clk);
      chk(data_ready == 1'b1, "R9 ready held", int'(data_ready), 1);
      ready_clr = 1'b1;
      @(negedge clk);
      ready_clr = 1'b0;
      chk(data_ready == 1'b0, "R9 ready cleared", int'(data_ready), 0);
      setup(1, 0, 0, 1'b0, 0, 0);
      ready_clr = 1'b1;
      pulse_start();
      wait_done(n, 200);
      chk(data_ready == 1'b1, "R9 set wins over clear", int'(data_ready), 1);
      @(negedge clk);
      chk(data_ready == 1'b0, "R9 clear after set", int'(data_ready), 0);
      ready_clr = 1'b0;

      // R10 stop mid second conversion: exactly one more done
      wait_done(n, 200);
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      cnt = 0;
      for (int i = 0; i < 100 && busy; i++) begin
         @(negedge clk);
         if (done) cnt++;
      end
      chk(cnt == 1, "R10 one done after stop", cnt, 1);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (done || busy) cnt++;
      end
      chk(cnt == 0, "R10 no restart after stop", cnt, 0);

      // R10 stop in periodic gap
      setup(2, 0, 0, 1'b0, 0, 40);
      pulse_start();
      wait_done(n, 200);
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R10 stop in gap", int'(busy), 0);
      cnt = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (done) cnt++;
      end
      chk(cnt == 0, "R10 gap no further done", cnt, 0);

      // R10 stop while idle ignored
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      @(negedge clk);
      run_single(0, 2, 0, 1'b0, 0, 16'h0A0A);

      // R11 enable drop mid conversion
      setup(1, 3, 2, 1'b0, 0, 0);
      pulse_start();
      repeat (5) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R11 idle after disable", int'(busy), 0);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (done) cnt++;
      end
      chk(cnt == 0, "R11 no done after abort", cnt, 0);
      enable = 1'b1;
      @(negedge clk);

      // R12 start while busy ignored, res captured at start
      setup(0, 3, 0, 1'b0, 0, 0);
      sample_in = 16'h5555;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      repeat (4) begin @(negedge clk); n++; end
      res = 2'd0;
      start = 1'b1;
      @(negedge clk);
      n++;
      start = 1'b0;
      while (!done && n < 500) begin @(negedge clk); n++; end
      chk(n == L3 + 1, "R12 latency unchanged by restart", n, L3 + 1);
      cnt = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (done) cnt++;
      end
      chk(cnt == 0, "R12 single done only", cnt, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule